// File: doc/BRIEF.md
# Sampling Delay Centre Trainer

This block picks the sampling delay for a source-synchronous receive lane. After reset it walks a delay tap from 0 to the top of its range. At each tap it issues a one-cycle load command. It then waits for one result from a downstream frame checker, which reports whether the video timing was recovered (locked) and a small status code that names the alignment it locked on.

The trainer groups consecutive locked taps into windows. A window ends when lock is lost, or when the status code changes while lock holds, because a code change means the checker found a different word alignment. The window that spans the most taps is kept. Its centre, computed as half of (first tap + last tap), becomes the final tap. That value is loaded once and then held with `done` high. If no tap ever locked, `fail` goes high and the final tap is 0.

Top module: `tap_center_trainer`

## Requirements
- R1: After reset is released the block starts the sweep at tap 0: `tap_load` is high with `tap_value` = 0, and `done` and `fail` are low.
- R2: Every tap from 0 to 2^TAP_W-1 is loaded exactly once, in ascending order. Each load is a one-cycle `tap_load` pulse, and the next tap is loaded only after one `chk_valid` is accepted for the current tap.
- R3: A `chk_valid` that arrives in the cycle `tap_load` is high is ignored. It neither advances the sweep nor counts as a sample.
- R4: A window opens at a tap whose sample is locked when the previous sample was unlocked. It grows while samples stay locked with an unchanged code, and it closes at the last locked tap before an unlocked sample.
- R5: A locked sample whose code differs from the previous locked sample's code closes the running window at the previous tap and opens a new one at the current tap.
- R6: A sample that is locked at the last tap (2^TAP_W-1) closes the running window with its end at that tap. This includes a window that opens at that tap.
- R7: A closed window replaces the kept one only if its width (last minus first) is strictly greater. Of two equally wide windows, the earlier one is kept.
- R8: Two cycles after the sample for the last tap is accepted, `tap_load` pulses with `tap_value` = `final_tap` = (first + last) >> 1 of the kept window. From that cycle on, `done` stays high and `tap_value` holds that value.
- R9: If no sample was locked, `fail` is high together with `done`, and `final_tap` and `tap_value` are 0.
- R10: A synchronous active-low reset clears all state and restarts the sweep, whether or not a sweep is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-domain clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chk_valid | input | 1 | One-cycle strobe: checker result is available |
| chk_locked | input | 1 | Checker found complete video timing |
| chk_code | input | CODE_W | Checker alignment/status code |
| tap_value | output | TAP_W | Tap value for the delay element |
| tap_load | output | 1 | One-cycle strobe to load `tap_value` |
| final_tap | output | TAP_W | Chosen centre tap, valid while `done` is high |
| done | output | 1 | Training finished, final tap loaded |
| fail | output | 1 | Training finished without any locked tap |

## Verification
Two functions can land on a single sample. When the locked code changes, one window closes and another opens at the same tap. At the last tap, the run is extended and the window is closed by the same sample. The bench provokes the first with patterns whose code changes in the middle of a locked run and exactly at the last tap. It provokes the second with runs that reach the top tap, including a pattern where only the top tap locks. A scoreboard model computes the widest run directly from the per-tap pattern, and its centre is compared with `final_tap` and `tap_value` when `done` rises.

// File: rtl/tct_pkg.sv
// Package: shared types for the sampling delay centre trainer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package tct_pkg;

    typedef enum logic [2:0] {
        ST_LOAD   = 3'd0,   // drive a tap and pulse the load
        ST_WAIT   = 3'd1,   // wait for one checker verdict
        ST_SETTLE = 3'd2,   // let the best-window keeper take the last capture
        ST_APPLY  = 3'd3,   // load the chosen tap
        ST_HOLD   = 3'd4    // training finished
    } sweep_st_t;

endpackage

// File: rtl/tct_sweep_fsm.sv
// Module: tct_sweep_fsm
// Steps the tap counter from 0 to its top value. It waits for exactly one
// checker result per tap, then applies the final tap and stays finished.
// Assumes the checker raises chk_valid some time after each load.
module tct_sweep_fsm
    import tct_pkg::*;
#(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    output logic             sample_stb,
    output logic [TAP_W-1:0] cur_tap,
    output logic             last_tap,
    output logic             load_cmd,
    output logic             finished
);
    localparam logic [TAP_W-1:0] TOP_TAP = {TAP_W{1'b1}};

    sweep_st_t state;

    // A result counts only while waiting; a result in a load cycle is dropped.
    assign sample_stb = (state == ST_WAIT) && chk_valid;
    assign last_tap   = (cur_tap == TOP_TAP);
    assign load_cmd   = (state == ST_LOAD) || (state == ST_APPLY);
    assign finished   = (state == ST_APPLY) || (state == ST_HOLD);

    // Sweep sequencing and tap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_LOAD;
            cur_tap <= '0;
        end else begin
            case (state)
                ST_LOAD:   state <= ST_WAIT;
                ST_WAIT: begin
                    if (chk_valid) begin
                        if (last_tap) begin
                            state <= ST_SETTLE;
                        end else begin
                            cur_tap <= cur_tap + 1'b1;
                            state   <= ST_LOAD;
                        end
                    end
                end
                ST_SETTLE: state <= ST_APPLY;
                ST_APPLY:  state <= ST_HOLD;
                default:   state <= ST_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/tct_window_track.sv
// Module: tct_window_track
// Follows runs of locked taps that share one status code. Each time a run
// ends, it emits a one-cycle capture with the run's first and last tap.
// Assumes samples arrive with strictly ascending taps.
module tct_window_track #(
    parameter int TAP_W  = 5,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic [TAP_W-1:0]  cur_tap,
    input  logic              last_tap,
    input  logic              chk_locked,
    input  logic [CODE_W-1:0] chk_code,
    output logic              cap_vld,
    output logic [TAP_W-1:0]  cap_min,
    output logic [TAP_W-1:0]  cap_max
);
    logic              prev_lock;
    logic [CODE_W-1:0] prev_code;
    logic [TAP_W-1:0]  run_lo;
    logic [TAP_W-1:0]  run_hi;
    logic              same_code;

    assign same_code = (chk_code == prev_code);

    // Open, extend and close runs as each accepted sample arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lock <= 1'b0;
            prev_code <= '0;
            run_lo    <= '0;
            run_hi    <= '0;
            cap_vld   <= 1'b0;
            cap_min   <= '0;
            cap_max   <= '0;
        end else begin
            cap_vld <= 1'b0;
            if (sample_stb) begin
                prev_lock <= chk_locked;
                prev_code <= chk_code;
                if (prev_lock && chk_locked && same_code) begin
                    run_hi <= cur_tap;
                    if (last_tap) begin
                        cap_vld <= 1'b1;
                        cap_min <= run_lo;
                        cap_max <= cur_tap;
                    end
                end else if (prev_lock && chk_locked) begin
                    cap_vld <= 1'b1;
                    cap_min <= run_lo;
                    cap_max <= run_hi;
                    run_lo  <= cur_tap;
                    run_hi  <= cur_tap;
                end else if (prev_lock) begin
                    cap_vld <= 1'b1;
                    cap_min <= run_lo;
                    cap_max <= run_hi;
                end else if (chk_locked) begin
                    run_lo <= cur_tap;
                    run_hi <= cur_tap;
                    if (last_tap) begin
                        cap_vld <= 1'b1;
                        cap_min <= cur_tap;
                        cap_max <= cur_tap;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tct_best_keep.sv
// Module: tct_best_keep
// Keeps the widest captured window and gives its midpoint. A later window
// wins only if it is strictly wider. Assumes cap_min <= cap_max.
module tct_best_keep #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_vld,
    input  logic [TAP_W-1:0] cap_min,
    input  logic [TAP_W-1:0] cap_max,
    output logic             best_valid,
    output logic [TAP_W-1:0] best_mid
);
    localparam int SUM_W = TAP_W + 1;

    logic [TAP_W-1:0] cap_width;
    logic [SUM_W-1:0] cap_sum;
    logic [TAP_W-1:0] best_width;
    logic [SUM_W-1:0] best_sum;
    logic             take;

    assign cap_width = cap_max - cap_min;
    assign cap_sum   = {1'b0, cap_max} + {1'b0, cap_min};
    assign take      = cap_vld && (!best_valid || (cap_width > best_width));
    assign best_mid  = best_sum[SUM_W-1:1];

    // Replace the kept window when a strictly wider one is captured.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_valid <= 1'b0;
            best_width <= '0;
            best_sum   <= '0;
        end else if (take) begin
            best_valid <= 1'b1;
            best_width <= cap_width;
            best_sum   <= cap_sum;
        end
    end

endmodule

// File: rtl/tap_center_trainer.sv
// Module: tap_center_trainer
// Top level: sweeps the delay taps, groups locked results into windows and
// loads the centre of the widest one. Assumes one checker verdict per load.
module tap_center_trainer #(
    parameter int TAP_W  = 5,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_locked,
    input  logic [CODE_W-1:0] chk_code,
    output logic [TAP_W-1:0]  tap_value,
    output logic              tap_load,
    output logic [TAP_W-1:0]  final_tap,
    output logic              done,
    output logic              fail
);
    logic             sample_stb;
    logic [TAP_W-1:0] cur_tap;
    logic             last_tap;
    logic             load_cmd;
    logic             finished;
    logic             cap_vld;
    logic [TAP_W-1:0] cap_min;
    logic [TAP_W-1:0] cap_max;
    logic             best_valid;
    logic [TAP_W-1:0] best_mid;

    tct_sweep_fsm #(.TAP_W(TAP_W)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .chk_valid  (chk_valid),
        .sample_stb (sample_stb),
        .cur_tap    (cur_tap),
        .last_tap   (last_tap),
        .load_cmd   (load_cmd),
        .finished   (finished)
    );

    tct_window_track #(.TAP_W(TAP_W), .CODE_W(CODE_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_stb (sample_stb),
        .cur_tap    (cur_tap),
        .last_tap   (last_tap),
        .chk_locked (chk_locked),
        .chk_code   (chk_code),
        .cap_vld    (cap_vld),
        .cap_min    (cap_min),
        .cap_max    (cap_max)
    );

    tct_best_keep #(.TAP_W(TAP_W)) u_best (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_vld    (cap_vld),
        .cap_min    (cap_min),
        .cap_max    (cap_max),
        .best_valid (best_valid),
        .best_mid   (best_mid)
    );

    // Final selection and shared tap port.
    assign final_tap = (finished && best_valid) ? best_mid : '0;
    assign tap_value = finished ? final_tap : cur_tap;
    assign tap_load  = load_cmd;
    assign done      = finished;
    assign fail      = finished && !best_valid;

endmodule

// File: rtl/tct_chk.sv
// Module: tct_chk
// Property checker for tap_center_trainer, attached with bind below.
// Assumes the synchronous active-low reset of the top level.
module tct_chk #(
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] tap_value,
    input logic             tap_load,
    input logic [TAP_W-1:0] final_tap,
    input logic             done,
    input logic             fail,
    input logic             cap_vld,
    input logic [TAP_W-1:0] cap_min,
    input logic [TAP_W-1:0] cap_max
);
    AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tap_load |=> !tap_load);                                          // R2
    AST_TAP_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n) && (tap_value != $past(tap_value)))
        |-> (tap_value == $past(tap_value) + 1'b1));                      // R2
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);                                                   // R8
    AST_DONE_SHOWS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tap_value == final_tap));                               // R8
    AST_FAIL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && (final_tap == '0)));                            // R9
    AST_CAP_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_vld |-> (cap_min <= cap_max));                                // R4
endmodule

bind tap_center_trainer tct_chk #(.TAP_W(TAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_value (tap_value),
    .tap_load  (tap_load),
    .final_tap (final_tap),
    .done      (done),
    .fail      (fail),
    .cap_vld   (cap_vld),
    .cap_min   (cap_min),
    .cap_max   (cap_max)
);

// File: tb/tb_tap_center_trainer.sv
// Bench: scoreboard. The driver sweeps one lock pattern per run and pushes
// the expected result. The monitor pops it and compares when done rises.
module tb_tap_center_trainer;
    localparam int TAP_W  = 5;
    localparam int CODE_W = 3;
    localparam int NTAP   = 1 << TAP_W;

    typedef struct {
        int tap;
        bit fl;
        string tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chk_valid = 1'b0;
    logic              chk_locked = 1'b0;
    logic [CODE_W-1:0] chk_code = '0;
    logic [TAP_W-1:0]  tap_value;
    logic              tap_load;
    logic [TAP_W-1:0]  final_tap;
    logic              done;
    logic              fail;

    int   total = 0;
    int   bad = 0;
    bit   lk [NTAP];
    int   cd [NTAP];
    exp_t q[$];
    bit   done_seen = 1'b0;

    always #4 clk = ~clk;

    tap_center_trainer #(.TAP_W(TAP_W), .CODE_W(CODE_W)) dut (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid),
        .chk_locked(chk_locked), .chk_code(chk_code),
        .tap_value(tap_value), .tap_load(tap_load),
        .final_tap(final_tap), .done(done), .fail(fail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_pat();
        for (int i = 0; i < NTAP; i++) begin
            lk[i] = 1'b0;
            cd[i] = 0;
        end
    endtask

    task automatic set_run(input int lo, input int hi, input int code);
        for (int i = lo; i <= hi; i++) begin
            lk[i] = 1'b1;
            cd[i] = code;
        end
    endtask

    // Reference: widest run of locked, same-code taps; earliest wins ties.
    task automatic push_expected(input string tag);
        exp_t e;
        int   start = 0;
        int   bw = -1;
        int   bmid = 0;
        for (int t = 0; t < NTAP; t++) begin
            if (lk[t] && (t == 0 || !lk[t-1] || cd[t] != cd[t-1])) start = t;
            if (lk[t] && (t == NTAP-1 || !lk[t+1] || cd[t+1] != cd[t])) begin
                if (t - start > bw) begin
                    bw = t - start;
                    bmid = (start + t) / 2;
                end
            end
        end
        e.tap = (bw < 0) ? 0 : bmid;
        e.fl  = (bw < 0);
        e.tag = tag;
        q.push_back(e);
    endtask

    // Driver: reset, sweep the pattern, check the tap sequence and final load.
    task automatic run_sweep(input string tag, input bit stray);
        push_expected(tag);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(tap_load && tap_value == 0 && !done && !fail, "R10 reset state",
              {tap_load, done, fail}, 3'b100);
        rst_n = 1'b1;
        for (int t = 0; t < NTAP; t++) begin
            check(tap_load == 1'b1, "R2 load pulse per tap", tap_load, 1);
            check(int'(tap_value) == t, t == 0 ? "R1 sweep starts at 0" : "R2 ascending tap",
                  tap_value, t);
            if (stray) begin
                chk_valid  = 1'b1;   // R3: arrives during the load cycle
                chk_locked = 1'b1;
                chk_code   = 3'd7;
            end
            @(negedge clk);
            chk_valid = 1'b0;
            check(!tap_load && int'(tap_value) == t, "R3 waits for verdict",
                  tap_value, t);
            @(negedge clk);
            check(!tap_load, "R2 no step without verdict", tap_load, 0);
            chk_valid  = 1'b1;
            chk_locked = lk[t];
            chk_code   = CODE_W'(cd[t]);
            @(negedge clk);
            chk_valid  = 1'b0;
            chk_locked = 1'b0;
        end
        check(!done && !tap_load, "R8 settle cycle", done, 0);
        @(negedge clk);
        check(tap_load && done, "R8 final load with done", {tap_load, done}, 2'b11);
        @(negedge clk);
        check(!tap_load && done, "R8 done held", {tap_load, done}, 2'b01);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare the result against the scoreboard when done rises.
    always @(negedge clk) begin
        if (!done) begin
            done_seen <= 1'b0;
        end else if (!done_seen) begin
            done_seen <= 1'b1;
            if (q.size() == 0) begin
                check(1'b0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(final_tap) == e.tap, {e.tag, " final_tap"}, final_tap, e.tap);
                check(int'(tap_value) == e.tap, {e.tag, " tap_value"}, tap_value, e.tap);
                check(fail == e.fl, {e.tag, " fail flag"}, fail, e.fl);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_pat();
        run_sweep("R9 no lock", 1'b0);

        clear_pat(); set_run(10, 20, 1);
        run_sweep("R4 single run", 1'b0);

        clear_pat(); set_run(10, 20, 1);
        run_sweep("R3 stray verdicts", 1'b1);

        clear_pat(); set_run(2, 5, 2); set_run(12, 25, 2);
        run_sweep("R7 wider later run", 1'b0);

        clear_pat(); set_run(0, NTAP-1, 4);
        run_sweep("R6 locked to top", 1'b0);

        clear_pat(); set_run(4, 15, 1); set_run(16, 20, 2);
        run_sweep("R5 code split", 1'b0);

        clear_pat(); set_run(1, 6, 3); set_run(20, 25, 3);
        run_sweep("R7 equal widths", 1'b0);

        clear_pat(); set_run(20, 30, 3); set_run(31, 31, 5);
        run_sweep("R5 code change at top", 1'b0);

        clear_pat(); set_run(31, 31, 6);
        run_sweep("R6 only top tap", 1'b0);

        // R10: reset in the middle of a sweep restarts it from tap 0.
        clear_pat(); set_run(8, 14, 1);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        run_sweep("R10 restart", 1'b0);

        check(q.size() == 0, "R8 all results seen", q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule